// File: doc/BRIEF.md
# Multi-Lane Pixel Deserializer with Parity Check

This block rebuilds display pixel words from one, two or three serial data lanes that share a high-speed bit clock. Each pixel travels as a 30-bit frame. The frame is gathered in a shift register. Its parity bit is then checked, and the 24 colour bits and 3 sync/enable bits are driven onto a registered 27-bit parallel bus. A one-cycle pixel-clock enable marks each completed frame.

A frame that fails parity is dropped. The bus keeps its previous word and an error pulse is raised for that pixel. A swap input can present the colour fields mirrored, to suit the routing of the receiving panel. When the receive enable is low, or the clock-present indication is low, the bus is parked in a fixed idle pattern. The block then loses frame alignment until the next frame-start strobe.

Top module: `pxd_deser`

## Requirements
- R1: `lane_sel` codes 00, 01 and 10 select 1, 2 and 3 lanes, giving 30, 15 and 10 bit periods per frame. Code 11 acts as 1 lane. Frame bit k travels on lane k mod N in period k div N, so bit 0 comes first. A `frame_start` high marks period 0 of a frame.
- R2: Frame bits 23:0 are pixel data, with red in 23:16, green in 15:8 and blue in 7:0. Bits 26:24 are VS, HS and DE (VS in 26, DE in 24). Bit 27 is an even parity bit over bits 26:0, and bits 29:28 have no effect on any output.
- R3: On a frame with good parity, `pix_bus` takes the new word in the cycle after the clock edge that ends the frame's last bit period. In that cycle `par_err` is low. Between frames, `pix_bus` does not change.
- R4: On a frame with bad parity, `pix_bus` keeps its previous word, and `par_err` is high for exactly the one cycle in which `pclk_en` marks that frame.
- R5: `pclk_en` is high for one cycle per completed frame, in the cycle after the edge that ends the last bit period. It is low at all other times.
- R6: With `swap` low, `pix_bus[26:3]` is red[7:0], green[7:0], blue[7:0] (MSB first) and `pix_bus[2:0]` is VS, HS, DE. With `swap` high, `pix_bus[26:3]` is blue[0:7], green[0:7], red[0:7], and `pix_bus[2:0]` is unchanged. `swap` is sampled at the frame's last bit period.
- R7: While `rx_en` or `clk_ok` is low, from the next edge on, `pclk_en`, `par_err` and DE (`pix_bus[0]`) are low, `pix_bus[26:1]` is all ones, and no frame completes.
- R8: After reset, and after any stretch with `rx_en` or `clk_ok` low, no frame completes before a `frame_start`. The held word starts as the idle pattern 27'h7FFFFFE.
- R9: A `frame_start` in the middle of a frame discards the bits collected so far and restarts the frame at period 0.
- R10: After one `frame_start`, further frames follow back to back without another strobe.
- R11: `lane_sel` may change at a frame boundary without a strobe. The next frame then uses the new lane count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low selects shutdown |
| clk_ok | input | 1 | Incoming clock is present |
| lane_sel | input | 2 | Lane-count code |
| swap | input | 1 | Mirror the colour field order |
| frame_start | input | 1 | Marks bit period 0 of a frame |
| lane_din | input | 3 | Serial data, one bit per lane |
| pix_bus | output | 27 | Registered pixel and sync bus |
| pclk_en | output | 1 | One-cycle pulse per completed frame |
| par_err | output | 1 | One-cycle parity-error pulse |

## Verification
The word, the pixel-clock pulse and the error flag of a frame all become visible one cycle after the edge that closes the frame's last bit period. The idle pattern appears one cycle after `rx_en` or `clk_ok` drops. The driver pushes the expected word and error flag while it drives the final bit period. The monitor samples on the falling edge and pops one entry for each `pclk_en` pulse, so every comparison falls in the cycle where that result is due. Any pulse with nothing queued is reported, and this is how the ignored-stimulus windows are checked.

// File: rtl/pxd_pkg.sv
package pxd_pkg;
  localparam int FRAME_W   = 30;
  localparam int COLOR_W   = 8;
  localparam int PIX_W     = 3 * COLOR_W;
  localparam int CTRL_W    = 3;
  localparam int BUS_W     = PIX_W + CTRL_W;
  localparam int PAR_BIT   = BUS_W;
  localparam int MAX_LANES = 3;
  localparam int LSEL_W    = 2;
  localparam int CNT_W     = $clog2(FRAME_W);

  localparam logic [BUS_W-1:0] IDLE_WORD = {{(BUS_W-1){1'b1}}, 1'b0};

  // lane-select code to number of active lanes
  function automatic logic [LSEL_W-1:0] lanes_of(input logic [LSEL_W-1:0] sel);
    case (sel)
      2'b01:   return 2'd2;
      2'b10:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  // bit periods per frame for a lane count
  function automatic logic [CNT_W-1:0] periods_of(input logic [LSEL_W-1:0] n);
    case (n)
      2'd2:    return CNT_W'(FRAME_W / 2);
      2'd3:    return CNT_W'(FRAME_W / 3);
      default: return CNT_W'(FRAME_W);
    endcase
  endfunction

  // even parity over data, control and parity bit
  function automatic logic parity_good(input logic [PAR_BIT:0] f);
    return ~^f;
  endfunction

  // frame to bus word, optionally mirrored colour fields
  function automatic logic [BUS_W-1:0] bus_map(input logic [PAR_BIT-1:0] f, input logic sw);
    logic [PIX_W-1:0] px;
    px = f[PIX_W-1:0];
    if (sw) begin
      for (int i = 0; i < PIX_W; i++) px[i] = f[PIX_W-1-i];
    end
    return {px, f[BUS_W-1:PIX_W]};
  endfunction
endpackage

// File: rtl/pxd_bit_counter.sv
module pxd_bit_counter
  import pxd_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int LW = LSEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          frame_start,
  input  logic [LW-1:0] nlanes,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] periods;
  logic          aligned;
  logic          last;

  always_comb begin
    periods = periods_of(nlanes);
    last    = (cnt >= periods - CW'(1));
    done    = active && aligned && !frame_start && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      aligned <= 1'b0;
    end else if (!active) begin
      cnt     <= '0;
      aligned <= 1'b0;
    end else if (frame_start) begin
      cnt     <= CW'(1);
      aligned <= 1'b1;
    end else if (aligned) begin
      cnt <= last ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/pxd_frame_shifter.sv
module pxd_frame_shifter
  import pxd_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int NL = MAX_LANES,
  parameter int LW = LSEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [LW-1:0] nlanes,
  input  logic [NL-1:0] din,
  output logic [FW-1:0] frame_nxt
);
  localparam int IDX_W = $clog2(FW);

  logic [FW-1:0]    sr;
  logic [IDX_W-1:0] pos;

  // shift right by the lane count, new bits enter at the top
  always_comb begin
    frame_nxt = sr >> nlanes;
    pos       = '0;
    for (int i = 0; i < NL; i++) begin
      if (i < int'(nlanes)) begin
        pos = IDX_W'(FW - int'(nlanes) + i);
        frame_nxt[pos] = din[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= '0;
    else if (active) sr <= frame_nxt;
  end
endmodule

// File: rtl/pxd_word_latch.sv
module pxd_word_latch
  import pxd_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int BW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          done,
  input  logic          swap,
  input  logic [FW-1:0] frame,
  output logic [BW-1:0] bus,
  output logic          pclk_en,
  output logic          par_err
);
  logic good;
  logic unused_rsvd;

  assign good        = parity_good(frame[PAR_BIT:0]);
  assign unused_rsvd = ^frame[FW-1:PAR_BIT+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus     <= IDLE_WORD;
      pclk_en <= 1'b0;
      par_err <= 1'b0;
    end else if (!active) begin
      bus     <= IDLE_WORD;
      pclk_en <= 1'b0;
      par_err <= 1'b0;
    end else begin
      pclk_en <= done;
      par_err <= done && !good;
      if (done && good) bus <= bus_map(frame[PAR_BIT-1:0], swap);
    end
  end
endmodule

// File: rtl/pxd_deser.sv
module pxd_deser
  import pxd_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int NL = MAX_LANES,
  parameter int BW = BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              clk_ok,
  input  logic [LSEL_W-1:0] lane_sel,
  input  logic              swap,
  input  logic              frame_start,
  input  logic [NL-1:0]     lane_din,
  output logic [BW-1:0]     pix_bus,
  output logic              pclk_en,
  output logic              par_err
);
  logic              active;
  logic [LSEL_W-1:0] nlanes;
  logic              frame_done;
  logic [FW-1:0]     frame_word;

  assign active = rx_en && clk_ok;
  assign nlanes = lanes_of(lane_sel);

  pxd_bit_counter #(.CW(CNT_W), .LW(LSEL_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .active(active), .frame_start(frame_start),
    .nlanes(nlanes), .done(frame_done)
  );

  pxd_frame_shifter #(.FW(FW), .NL(NL), .LW(LSEL_W)) shf_i (
    .clk(clk), .rst_n(rst_n), .active(active), .nlanes(nlanes),
    .din(lane_din), .frame_nxt(frame_word)
  );

  pxd_word_latch #(.FW(FW), .BW(BW)) lat_i (
    .clk(clk), .rst_n(rst_n), .active(active), .done(frame_done),
    .swap(swap), .frame(frame_word), .bus(pix_bus),
    .pclk_en(pclk_en), .par_err(par_err)
  );
endmodule

// File: rtl/pxd_deser_chk.sv
module pxd_deser_chk #(
  parameter int BW = 27
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          clk_ok,
  input logic [BW-1:0] pix_bus,
  input logic          pclk_en,
  input logic          par_err,
  input logic          frame_done
);
  localparam logic [BW-1:0] IDLE = {{(BW-1){1'b1}}, 1'b0};

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_en && clk_ok) |=> (pix_bus == IDLE && !pclk_en && !par_err));

  p_pclk_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_en |=> !pclk_en);

  p_done_pclk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> pclk_en);

  p_err_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> !par_err);

  p_err_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $stable(pix_bus));

  p_err_pclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> pclk_en);

  p_bus_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pclk_en && $past(rx_en && clk_ok)) |-> $stable(pix_bus));
endmodule

bind pxd_deser pxd_deser_chk #(.BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .clk_ok(clk_ok),
  .pix_bus(pix_bus), .pclk_en(pclk_en), .par_err(par_err),
  .frame_done(frame_done)
);

// File: tb/pxd_deser_tb_top.sv
module pxd_deser_tb_top;
  localparam logic [26:0] IDLE = 27'h7FFFFFE;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_en, clk_ok, swap, frame_start;
  logic [1:0]  lane_sel;
  logic [2:0]  lane_din;
  logic [26:0] pix_bus;
  logic        pclk_en, par_err;

  int n_chk = 0;
  int n_err = 0;
  int pulses = 0;
  bit finished = 0;
  logic [27:0] expq[$];   // {err, word}
  logic [26:0] held;

  always #4 clk = ~clk;

  pxd_deser dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .clk_ok(clk_ok),
    .lane_sel(lane_sel), .swap(swap), .frame_start(frame_start),
    .lane_din(lane_din), .pix_bus(pix_bus), .pclk_en(pclk_en), .par_err(par_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [29:0] make_frame(input logic [23:0] px, input logic [2:0] ctl,
                                             input logic [1:0] rsvd, input bit corrupt);
    logic p;
    p = 1'b0;
    for (int i = 0; i < 24; i++) p = p ^ px[i];
    for (int i = 0; i < 3; i++) p = p ^ ctl[i];
    return {rsvd, p ^ corrupt, ctl, px};
  endfunction

  // monitor: compare at the falling edge, one entry per pixel pulse
  always @(negedge clk) begin
    if (rst_n && pclk_en) begin
      logic [27:0] e;
      pulses++;
      if (expq.size() == 0) begin
        chk(1'b0, "R5/R7/R8 unexpected pclk_en", {4'h0, par_err, pix_bus}, 32'h0);
      end else begin
        e = expq.pop_front();
        chk(pix_bus == e[26:0], "R3/R4/R6 word", {5'h0, pix_bus}, {5'h0, e[26:0]});
        chk(par_err == e[27], "R3/R4 par_err", {31'h0, par_err}, {31'h0, e[27]});
      end
    end
  end

  // driver: send one frame; bit k on lane k mod n in period k div n
  task automatic send_frame(input logic [29:0] f, input logic [1:0] sel, input bit sw, input bit strobe);
    int n, per;
    logic [26:0] w;
    n   = (sel == 2'b01) ? 2 : (sel == 2'b10) ? 3 : 1;
    per = 30 / n;
    for (int p = 0; p < per; p++) begin
      @(negedge clk);
      lane_sel    = sel;
      swap        = sw;
      frame_start = strobe && (p == 0);
      lane_din    = 3'b000;
      for (int l = 0; l < n; l++) lane_din[l] = f[p*n + l];
      if (p == per - 1) begin
        bit bad;
        bad = 1'b0;
        for (int i = 0; i < 28; i++) bad = bad ^ f[i];
        if (!bad) begin
          w[2:0] = f[26:24];
          for (int i = 0; i < 24; i++) w[3+i] = sw ? f[23-i] : f[i];
          held = w;
        end
        expq.push_back({bad, held});
      end
    end
  endtask

  task automatic drive_garbage(input int cycles, input bit strobe_first);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      frame_start = strobe_first && (c == 0);
      lane_din    = 3'(c * 5 + 3);
    end
  endtask

  task automatic check_idle(input string req);
    chk(pix_bus == IDLE, req, {5'h0, pix_bus}, {5'h0, IDLE});
    chk(!pclk_en && !par_err, req, {30'h0, pclk_en, par_err}, 32'h0);
  endtask

  initial begin
    int p0;
    rst_n = 1'b0; rx_en = 1'b1; clk_ok = 1'b1; swap = 1'b0;
    frame_start = 1'b0; lane_sel = 2'b00; lane_din = 3'b000;
    held = IDLE;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R8 reset state");

    // R1 R3: one lane, then two, three, and code 11
    send_frame(make_frame(24'hA5C3E1, 3'b101, 2'b00, 0), 2'b00, 0, 1);
    send_frame(make_frame(24'h123456, 3'b011, 2'b00, 0), 2'b01, 0, 1);
    send_frame(make_frame(24'hF00F81, 3'b110, 2'b00, 0), 2'b10, 0, 1);
    send_frame(make_frame(24'h0055AA, 3'b001, 2'b00, 0), 2'b11, 0, 1);
    // R6 swap
    send_frame(make_frame(24'h80C001, 3'b010, 2'b00, 0), 2'b10, 1, 1);
    // R4 bad parity holds previous word
    send_frame(make_frame(24'hDEADBE, 3'b111, 2'b00, 1), 2'b10, 0, 1);
    // R10 back to back without strobe; R11 lane change at boundary
    send_frame(make_frame(24'h3C3C3C, 3'b100, 2'b00, 0), 2'b10, 0, 0);
    send_frame(make_frame(24'h0F1E2D, 3'b011, 2'b00, 0), 2'b01, 0, 0);
    // R2 reserved bits have no effect
    send_frame(make_frame(24'h777777, 3'b101, 2'b11, 0), 2'b01, 0, 1);
    send_frame(make_frame(24'h777777, 3'b101, 2'b10, 0), 2'b10, 0, 1);
    @(negedge clk);
    @(negedge clk);
    chk(pix_bus == 27'h3BBBBBD, "R2 reserved bits ignored", {5'h0, pix_bus}, 32'h3BBBBBD);
    chk(expq.size() == 0, "R5 all frames produced", expq.size(), 0);

    // R7 clock loss: idle, lanes ignored
    clk_ok = 1'b0;
    @(negedge clk);
    check_idle("R7 clock lost");
    p0 = pulses;
    drive_garbage(35, 1);
    check_idle("R7 idle held");
    held = IDLE;
    // R8 no completion without strobe after recovery
    clk_ok = 1'b1;
    drive_garbage(40, 0);
    chk(pulses == p0, "R8 no frame without strobe", pulses, p0);
    // R8 first frame bad: idle pattern held
    send_frame(make_frame(24'h111111, 3'b001, 2'b00, 1), 2'b10, 0, 1);
    send_frame(make_frame(24'h222222, 3'b001, 2'b00, 0), 2'b10, 0, 1);

    // R7 shutdown via rx_en
    @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk);
    check_idle("R7 shutdown");
    held = IDLE;
    rx_en = 1'b1;

    // R9 realignment after partial frame
    drive_garbage(7, 1);
    send_frame(make_frame(24'hC0FFEE, 3'b110, 2'b01, 0), 2'b00, 1, 1);
    drive_garbage(4, 1);
    send_frame(make_frame(24'h13579B, 3'b010, 2'b00, 0), 2'b10, 0, 1);
    @(negedge clk);
    frame_start = 1'b0;
    @(negedge clk);
    chk(expq.size() == 0, "R9 realigned frames produced", expq.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule